// File: doc/BRIEF.md
# Timestamped Edge Capture Unit

This block watches four external input lines and records when they change. Each line is resynchronised, and an edge detector then checks it against the edge mode set for that line. When a qualifying edge occurs, the unit captures the current value of a free-running timer that comes in from outside the block. It also notes which lines fired in that clock cycle. The resulting entry, a line mask plus a timestamp, is written into a small FIFO.

The oldest FIFO entry moves by itself into a holding register, and the processor reads it from there. Reading the holding register frees it for the next entry. The unit raises two interrupt pulses: one each time the holding register is loaded, and one when the FIFO reaches a fill mark. A sticky flag records that an event was lost because all storage was full. Bus decoding and interrupt vectoring are left to the surrounding logic.

Top module: `edge_stamp_unit`

## Requirements
- R1: After reset, `hold_valid_o`, `fifo_level_o`, `overflow_o`, `irq_hold_o` and `irq_fill_o` are all 0, and every line is disabled.
- R2: Each line passes through two synchronising flops. A change on a line that is sampled at clock edge E1 produces an entry whose timestamp is the `timer_i` value sampled at edge E3.
- R3: A `cfg_we_i` pulse writes `cfg_mode_i` and `cfg_en_i` for the line `cfg_line_i`. Mode code 0 fires on rising edges only, code 1 on falling edges only, and code 2 on both edges.
- R4: Mode code 3 fires on every eighth rising edge of the line, counted since the most recent mode write to that line. Any such write restarts the count.
- R5: A line whose enable is 0 creates no entry, whatever it does.
- R6: All lines that fire in the same cycle share one entry. Bit i of the entry's mask is set when line i fired.
- R7: Entries reach the holding register in arrival order. When the holding register is empty and the FIFO is not, the oldest FIFO entry moves into it on the next clock. A `hold_pop_i` pulse empties the holding register. Up to 8 entries can be stored: 7 in the FIFO and 1 in the holding register.
- R8: An event that arrives while all 8 places are full is dropped. It then sets `overflow_o`, which stays at 1 until reset.
- R9: `irq_hold_o` is high for exactly one cycle each time an entry is loaded into the holding register, in the first cycle that `hold_valid_o` shows that entry.
- R10: `irq_fill_o` is high for one cycle after a write raises the FIFO count from 5 to 6.
- R11: `fifo_level_o` gives the number of entries in the FIFO. The entry in the holding register is not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, applied synchronously |
| timer_i | input | 16 | Free-running timer value to capture |
| line_i | input | 4 | Asynchronous lines being watched |
| cfg_we_i | input | 1 | Write strobe for one line's configuration |
| cfg_line_i | input | 2 | Line selected by the configuration write |
| cfg_mode_i | input | 2 | Edge mode code (0 rise, 1 fall, 2 both, 3 every eighth rise) |
| cfg_en_i | input | 1 | Enable for the selected line |
| hold_pop_i | input | 1 | Read strobe that empties the holding register |
| hold_valid_o | output | 1 | Holding register contains an entry |
| hold_mask_o | output | 4 | Mask of the lines that fired for the held entry |
| hold_stamp_o | output | 16 | Timestamp of the held entry |
| fifo_level_o | output | 3 | Number of entries waiting in the FIFO |
| overflow_o | output | 1 | Sticky flag: an event was dropped |
| irq_hold_o | output | 1 | One-cycle pulse when the holding register is loaded |
| irq_fill_o | output | 1 | One-cycle pulse when the FIFO reaches the fill mark |

## Verification
Some properties are checked by assertions on every cycle:
- the delay from input to event,
- the FIFO never being written while full unless it is also read in that cycle,
- the automatic move into an empty holding register,
- the holding register emptying on a pop,
- the sticky overflow flag,
- the fill interrupt matching the FIFO count.

Other behaviour only the bench scenarios can show. These are the exact timestamp values, the mask of simultaneous lines, the eighth-edge count and its restart on a mode write, the exact set of entries kept when storage runs out, and the one-to-one match between holding-register interrupts and entries read.

// File: rtl/esu_pkg.sv
package esu_pkg;

  typedef enum logic [1:0] {
    EDGE_RISE  = 2'd0,
    EDGE_FALL  = 2'd1,
    EDGE_BOTH  = 2'd2,
    EDGE_RISE8 = 2'd3
  } edge_mode_e;

  // Decide whether a line qualifies this cycle, given its mode and the edges seen.
  function automatic logic edge_hit(edge_mode_e m, logic rise, logic fall, logic wrap);
    case (m)
      EDGE_RISE: return rise;
      EDGE_FALL: return fall;
      EDGE_BOTH: return rise | fall;
      default:   return rise & wrap;
    endcase
  endfunction

endpackage

// File: rtl/esu_line_detect.sv
module esu_line_detect
  import esu_pkg::*;
#(
  parameter int PRESCALE = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       line_i,
  input  edge_mode_e mode_i,
  input  logic       en_i,
  input  logic       mode_wr_i,
  output logic       hit_o
);
  localparam int CW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;

  logic [1:0]    sync_q;
  logic          prev_q;
  logic [CW-1:0] cnt_q;
  logic          rise, fall, wrap;

  assign rise = sync_q[1] & ~prev_q;
  assign fall = ~sync_q[1] & prev_q;
  assign wrap = (cnt_q == CW'(PRESCALE - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[0], line_i};
      prev_q <= sync_q[1];
    end
  end

  // Count rising edges in divide mode; any mode write restarts the count.
  always_ff @(posedge clk) begin
    if (!rst_n || mode_wr_i) begin
      cnt_q <= '0;
    end else if (en_i && mode_i == EDGE_RISE8 && rise) begin
      cnt_q <= wrap ? '0 : cnt_q + 1'b1;
    end
  end

  assign hit_o = en_i & edge_hit(mode_i, rise, fall, wrap);

  // The line changed two edges before this event was seen.
  assert_sync_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
    hit_o |-> ($past(line_i, 2) != $past(line_i, 3)));

endmodule

// File: rtl/esu_fifo.sv
module esu_fifo #(
  parameter int W     = 20,
  parameter int DEPTH = 7
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       push_i,
  input  logic [W-1:0]               wdata_i,
  input  logic                       pop_i,
  output logic [W-1:0]               rdata_o,
  output logic                       empty_o,
  output logic                       full_o,
  output logic [$clog2(DEPTH+1)-1:0] level_o
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int LW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem_q [DEPTH];
  logic [PW-1:0] wr_q, rd_q;
  logic [LW-1:0] cnt_q;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == LW'(DEPTH));
  assign level_o = cnt_q;
  assign rdata_o = mem_q[rd_q];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_i) wr_q <= bump(wr_q);
      if (pop_i)  rd_q <= bump(rd_q);
      case ({push_i, pop_i})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (push_i) mem_q[wr_q] <= wdata_i;
  end

  assert_no_overrun_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && full_o) |-> pop_i);

  assert_no_underrun_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pop_i |-> !empty_o);

endmodule

// File: rtl/esu_hold_stage.sv
module esu_hold_stage #(
  parameter int W = 20
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         src_valid_i,
  input  logic [W-1:0] src_data_i,
  input  logic         pop_i,
  output logic         take_o,
  output logic         valid_o,
  output logic [W-1:0] data_o,
  output logic         load_pulse_o
);
  logic         valid_q, load_q;
  logic [W-1:0] data_q;

  assign take_o = src_valid_i && (!valid_q || pop_i);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      load_q  <= 1'b0;
      data_q  <= '0;
    end else begin
      load_q <= take_o;
      if (take_o) begin
        valid_q <= 1'b1;
        data_q  <= src_data_i;
      end else if (pop_i) begin
        valid_q <= 1'b0;
      end
    end
  end

  assign valid_o      = valid_q;
  assign data_o       = data_q;
  assign load_pulse_o = load_q;

  assert_pop_empties_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && pop_i && !src_valid_i) |=> !valid_q);

endmodule

// File: rtl/edge_stamp_unit.sv
module edge_stamp_unit
  import esu_pkg::*;
#(
  parameter int LINES     = 4,
  parameter int TW        = 16,
  parameter int DEPTH     = 7,
  parameter int FILL_MARK = 6,
  parameter int PRESCALE  = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [TW-1:0]              timer_i,
  input  logic [LINES-1:0]           line_i,
  input  logic                       cfg_we_i,
  input  logic [$clog2(LINES)-1:0]   cfg_line_i,
  input  logic [1:0]                 cfg_mode_i,
  input  logic                       cfg_en_i,
  input  logic                       hold_pop_i,
  output logic                       hold_valid_o,
  output logic [LINES-1:0]           hold_mask_o,
  output logic [TW-1:0]              hold_stamp_o,
  output logic [$clog2(DEPTH+1)-1:0] fifo_level_o,
  output logic                       overflow_o,
  output logic                       irq_hold_o,
  output logic                       irq_fill_o
);
  localparam int EW = LINES + TW;
  localparam int LW = $clog2(DEPTH + 1);
  localparam int SW = $clog2(LINES);

  edge_mode_e       mode_q [LINES];
  logic [LINES-1:0] en_q;
  logic [LINES-1:0] hit;

  logic          any_hit, push, drop, fifo_take;
  logic          fifo_empty, fifo_full;
  logic [EW-1:0] fifo_rdata, hold_data;
  logic [LW-1:0] level;
  logic          ovf_q, fill_q;

  for (genvar i = 0; i < LINES; i++) begin : g_line
    logic wr_here;
    assign wr_here = cfg_we_i && (cfg_line_i == SW'(i));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        mode_q[i] <= EDGE_RISE;
        en_q[i]   <= 1'b0;
      end else if (wr_here) begin
        mode_q[i] <= edge_mode_e'(cfg_mode_i);
        en_q[i]   <= cfg_en_i;
      end
    end

    esu_line_detect #(.PRESCALE(PRESCALE)) u_det (
      .clk       (clk),
      .rst_n     (rst_n),
      .line_i    (line_i[i]),
      .mode_i    (mode_q[i]),
      .en_i      (en_q[i]),
      .mode_wr_i (wr_here),
      .hit_o     (hit[i])
    );
  end

  // An entry may be written into a full FIFO only while the hold stage takes one out.
  assign any_hit = |hit;
  assign push    = any_hit && (!fifo_full || fifo_take);
  assign drop    = any_hit && !push;

  esu_fifo #(.W(EW), .DEPTH(DEPTH)) u_fifo (
    .clk     (clk),
    .rst_n   (rst_n),
    .push_i  (push),
    .wdata_i ({hit, timer_i}),
    .pop_i   (fifo_take),
    .rdata_o (fifo_rdata),
    .empty_o (fifo_empty),
    .full_o  (fifo_full),
    .level_o (level)
  );

  esu_hold_stage #(.W(EW)) u_hold (
    .clk          (clk),
    .rst_n        (rst_n),
    .src_valid_i  (!fifo_empty),
    .src_data_i   (fifo_rdata),
    .pop_i        (hold_pop_i),
    .take_o       (fifo_take),
    .valid_o      (hold_valid_o),
    .data_o       (hold_data),
    .load_pulse_o (irq_hold_o)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ovf_q  <= 1'b0;
      fill_q <= 1'b0;
    end else begin
      if (drop) ovf_q <= 1'b1;
      fill_q <= push && !fifo_take && (level == LW'(FILL_MARK - 1));
    end
  end

  assign hold_mask_o  = hold_data[EW-1:TW];
  assign hold_stamp_o = hold_data[TW-1:0];
  assign fifo_level_o = level;
  assign overflow_o   = ovf_q;
  assign irq_fill_o   = fill_q;

  assert_sticky_ovf_R8: assert property (@(posedge clk) disable iff (!rst_n)
    overflow_o |=> overflow_o);

  assert_fill_level_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_fill_o |-> (fifo_level_o == LW'(FILL_MARK)));

  assert_auto_move_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold_valid_o && fifo_level_o != '0) |=> hold_valid_o);

  assert_irq_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_hold_o |-> hold_valid_o);

endmodule

// File: tb/edge_stamp_unit_bench.sv
module edge_stamp_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] tmr = 16'h1230;
  logic [3:0]  lines = '0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_line = '0;
  logic [1:0]  cfg_mode = '0;
  logic        cfg_en = 1'b0;
  logic        hold_pop = 1'b0;
  logic        hold_valid;
  logic [3:0]  hold_mask;
  logic [15:0] hold_stamp;
  logic [2:0]  fifo_level;
  logic        overflow, irq_hold, irq_fill;

  int n_chk = 0, n_fail = 0;
  int n_hold_irq = 0, n_fill_irq = 0, n_got = 0;
  bit mon_on = 1'b1;
  bit done = 1'b0;
  logic [19:0] exp_q[$];
  int m_mode[4];
  bit m_en[4];
  int m_cnt[4];

  always #10 clk = ~clk;
  always @(posedge clk) tmr <= tmr + 16'd1;

  edge_stamp_unit u_edge_stamp_unit (
    .clk(clk), .rst_n(rst_n), .timer_i(tmr), .line_i(lines),
    .cfg_we_i(cfg_we), .cfg_line_i(cfg_line), .cfg_mode_i(cfg_mode), .cfg_en_i(cfg_en),
    .hold_pop_i(hold_pop), .hold_valid_o(hold_valid), .hold_mask_o(hold_mask),
    .hold_stamp_o(hold_stamp), .fifo_level_o(fifo_level), .overflow_o(overflow),
    .irq_hold_o(irq_hold), .irq_fill_o(irq_fill)
  );

  task automatic check(bit ok, string req, int act, int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", req, act, expv);
    end
  endtask

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  // Driver: writes one line's config and keeps the model in step (R3, R4).
  task automatic cfg(int ln, int md, bit en);
    @(negedge clk);
    cfg_we = 1'b1; cfg_line = 2'(ln); cfg_mode = 2'(md); cfg_en = en;
    m_mode[ln] = md; m_en[ln] = en; m_cnt[ln] = 0;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // Driver: applies a new line pattern and queues the entry the model expects.
  task automatic drive(logic [3:0] nv);
    logic [3:0] mask;
    mask = '0;
    for (int i = 0; i < 4; i++) begin
      bit r, f, hit;
      r = !lines[i] && nv[i];
      f = lines[i] && !nv[i];
      hit = 1'b0;
      if (m_en[i]) begin
        case (m_mode[i])
          0: hit = r;
          1: hit = f;
          2: hit = r || f;
          default: if (r) begin
            m_cnt[i]++;
            if (m_cnt[i] == 8) begin hit = 1'b1; m_cnt[i] = 0; end
          end
        endcase
      end
      mask[i] = hit;
    end
    if (mask != 0 && (mon_on || exp_q.size() < 8))
      exp_q.push_back({mask, 16'(tmr + 16'd2)});
    lines = nv;
    repeat (4) @(negedge clk);
  endtask

  // Monitor: pops the holding register and compares it against the scoreboard.
  always @(negedge clk) begin
    if (rst_n) begin
      if (irq_hold) n_hold_irq++;
      if (irq_fill) n_fill_irq++;
    end
    if (rst_n && mon_on && hold_valid) begin
      n_got++;
      if (exp_q.size() == 0) begin
        check(1'b0, "R5 unexpected entry", {hold_mask, hold_stamp}, 0);
      end else begin
        logic [19:0] e;
        e = exp_q.pop_front();
        check(hold_mask == e[19:16], "R6 mask", hold_mask, e[19:16]);
        check(hold_stamp == e[15:0], "R2 stamp", hold_stamp, e[15:0]);
      end
      hold_pop = 1'b1;
    end else begin
      hold_pop = 1'b0;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      check(1'b0, "R7 watchdog", 0, 1);
      finish_up();
    end
  end

  initial begin
    for (int i = 0; i < 4; i++) begin m_mode[i] = 0; m_en[i] = 0; m_cnt[i] = 0; end
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(!hold_valid, "R1 hold_valid", hold_valid, 0);
    check(fifo_level == 0, "R1 level", fifo_level, 0);
    check(!overflow, "R1 overflow", overflow, 0);
    check(!irq_hold && !irq_fill, "R1 irqs", {irq_hold, irq_fill}, 0);

    // R5: lines disabled after reset; toggling them stores nothing
    drive(4'b1111);
    drive(4'b0000);
    check(!hold_valid && fifo_level == 0, "R5 disabled quiet", {hold_valid, fifo_level}, 0);

    // R3 rising only on line 0
    cfg(0, 0, 1);
    drive(4'b0001);
    drive(4'b0000);
    // R3 falling only on line 1
    cfg(1, 1, 1);
    drive(4'b0010);
    drive(4'b0000);
    // R3 both edges on line 2
    cfg(2, 2, 1);
    drive(4'b0100);
    drive(4'b0000);
    // R5 disable line 2 again
    cfg(2, 2, 0);
    drive(4'b0100);
    drive(4'b0000);
    repeat (6) @(negedge clk);
    check(exp_q.size() == 0, "R3 all entries seen", exp_q.size(), 0);

    // R6 simultaneous lines share one entry
    cfg(1, 0, 1);
    cfg(2, 0, 1);
    drive(4'b0110);
    drive(4'b0000);

    // R4 every eighth rising edge, restart on mode write
    cfg(3, 3, 1);
    for (int k = 0; k < 12; k++) begin drive(4'b1000); drive(4'b0000); end
    cfg(3, 3, 1);
    for (int k = 0; k < 8; k++) begin drive(4'b1000); drive(4'b0000); end
    repeat (6) @(negedge clk);
    check(exp_q.size() == 0, "R4 all entries seen", exp_q.size(), 0);
    check(!hold_valid, "R7 drained", hold_valid, 0);
    check(n_fill_irq == 0, "R10 no early fill irq", n_fill_irq, 0);

    // R8 fill all storage with the reader stalled
    cfg(1, 0, 0);
    cfg(2, 0, 0);
    cfg(3, 0, 0);
    cfg(0, 2, 1);
    mon_on = 1'b0;
    check(!overflow, "R8 no overflow yet", overflow, 0);
    for (int k = 0; k < 9; k++) drive(lines ^ 4'b0001);
    check(fifo_level == 7, "R11 level full", fifo_level, 7);
    check(hold_valid, "R7 hold full", hold_valid, 1);
    check(overflow, "R8 overflow set", overflow, 1);
    check(n_fill_irq == 1, "R10 fill irq once", n_fill_irq, 1);
    check(exp_q.size() == 8, "R7 capacity", exp_q.size(), 8);
    mon_on = 1'b1;
    repeat (30) @(negedge clk);
    check(exp_q.size() == 0, "R7 order and drain", exp_q.size(), 0);
    check(fifo_level == 0, "R11 level empty", fifo_level, 0);
    check(overflow, "R8 overflow sticky", overflow, 1);
    check(n_hold_irq == n_got, "R9 one irq per load", n_hold_irq, n_got);
    check(n_fill_irq == 1, "R10 fill irq total", n_fill_irq, 1);
    done = 1'b1;
    finish_up();
  end
endmodule